// File: doc/BRIEF.md
# Per-Area External Memory Wait-State Controller

This block connects an internal request port to an asynchronous external memory bus for SRAM, ROM or flash devices. The top address bits of each request pick one of several chip-select areas. The block drives that area's active-low select, a read or write strobe, the external address and the write data. When the access is complete it returns a one-cycle ready pulse and, for reads, the captured data.

Areas share settings in adjacent pairs. Each pair stores three settings: the device width (8 or 16 bits), the number of added wait cycles (0 to 7) and an output-disable recovery delay (0.5 to 3.5 bus cycles). The controller runs on a clock at twice the bus rate, so one tick of `clk` is half a bus cycle. This lets the recovery delay be counted in half-cycle steps. The recovery delay is inserted only when an access moves to a different area from the previous access.

A 16-bit request to an 8-bit area is carried out as two byte accesses, low byte first, with a single ready at the end. The requester holds its request fields stable until it sees ready, and it has only one access outstanding at a time.

Top module: `emw_ctrl`

## Requirements
- R1: The area index is `req_addr[ADDR_W-1 -: 3]` (8 areas). During an access only that area's `ext_cs_n` bit is low. All other bits stay high.
- R2: For a read, each strobe (`ext_rd_n` low) lasts 2*(1+W) ticks, where W is the wait field of the area's pair.
- R3: A write strobe (`ext_wr_n` low) lasts 2*(1+max(W,1)) ticks. A wait field of 0 therefore still gives 4 ticks.
- R4: The delay field is D. If the previous access used a different area, all selects stay high for 2*D+1 ticks before the new access starts. D is taken from the pair of the area being left.
- R5: No recovery gap is inserted when an access targets the same area as the previous one, or when it is the first access after reset.
- R6: A wide request (`req_wide`=1) to an area whose pair is 8-bit makes two strobes. The first uses address bit 0 = 0 and lane [7:0] = low byte. The second uses bit 0 = 1 and lane [7:0] = high byte. One tick with the strobe high separates them, the select stays low throughout, and read data is assembled as {second byte, first byte}.
- R7: A narrow request (`req_wide`=0) makes one strobe at the given address. It writes `req_wdata` on the bus and returns `{8'h00, ext_din[7:0]}` on reads.
- R8: After reset all selects and strobes are high, ready is low, and every pair reads back 6'h3F. That value means 16-bit width, 7 wait cycles and the largest delay.
- R9: The configuration word is: bit 5 = width (1 means 16-bit), bits 4:2 = wait, bits 1:0 = delay. A write stores the word for pair `cfg_pair`, and both areas 2p and 2p+1 use it. `cfg_rdata` shows the word of the selected pair.
- R10: Ready is high for exactly one tick, at 1 tick after the last strobe ends. `rsp_rdata` holds the read result while ready is high. The latency from request to ready is gap + strobe ticks (+1 between split bytes) + 1.
- R11: The read and write strobes are never low together. A strobe is low only while a select is low, and only the strobe that matches `req_write` is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the bus rate (one tick = half a bus cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the per-pair setting |
| cfg_pair | input | 2 | Pair index for writing and reading back settings |
| cfg_wdata | input | 6 | Setting word: width, wait, delay |
| cfg_rdata | output | 6 | Setting word of the selected pair |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte request |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 16 | Write data |
| rsp_ready | output | 1 | One-tick completion pulse |
| rsp_rdata | output | 16 | Read result |
| ext_cs_n | output | 8 | Active-low select per area |
| ext_addr | output | 16 | External address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | Write data drive enable |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
The bench computes ready latency from its own copy of the settings and the last area. Latency is the recovery gap (2*D+1), plus 2*(1+W) per byte strobe, plus one tick between split bytes, plus one tick into the ready state. The bench counts rising edges from the request until it sees ready at a falling edge. Strobe widths, pulse counts, addresses and data lanes are sampled at falling edges, midway between the edges that move the state. Read data is compared in the same falling-edge sample where ready is seen, and the following falling edge checks that ready has dropped.

// File: rtl/emw_pkg.sv
// Shared types for the external memory wait-state controller.
// Assumes a 16-bit external data bus and per-pair settings of 6 bits.
package emw_pkg;
    localparam int BUS_W = 16;
    localparam int CFG_W = 6;

    typedef struct packed {
        logic       wide;   // 1 = 16-bit device, 0 = 8-bit device
        logic [2:0] wcnt;   // added wait cycles (bus cycles)
        logic [1:0] od;     // recovery delay code, 2*od+1 half cycles
    } area_cfg_t;

    localparam area_cfg_t CFG_RESET = '{wide: 1'b1, wcnt: 3'd7, od: 2'd3};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_STRB,
        ST_MID,
        ST_DONE
    } seq_st_t;
endpackage

// File: rtl/emw_cfg_bank.sv
// Per-pair settings storage. One word serves two neighbouring areas.
// Assumes N_PAIRS is a power of two; reset loads the slow boot default.
module emw_cfg_bank
    import emw_pkg::*;
#(
    parameter  int N_PAIRS = 4,
    localparam int PAIR_W  = $clog2(N_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAIR_W-1:0] wr_pair,
    input  area_cfg_t         wr_data,
    input  logic [PAIR_W-1:0] rd_pair,
    output area_cfg_t         rd_data,
    output area_cfg_t         cfg_all [N_PAIRS]
);
    area_cfg_t regs [N_PAIRS];

    // Load defaults on reset, otherwise store a written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PAIRS; i++) regs[i] <= CFG_RESET;
        end else if (wr_en) begin
            regs[wr_pair] <= wr_data;
        end
    end

    // Present the stored words to the sequencer and the read port.
    always_comb begin
        for (int i = 0; i < N_PAIRS; i++) cfg_all[i] = regs[i];
        rd_data = regs[rd_pair];
    end

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_chk
        AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_pair == PAIR_W'(g)) |=> (regs[g] == $past(wr_data))); // R9
        AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_pair == PAIR_W'(g)) |=> $stable(regs[g])); // R9
    end
endmodule

// File: rtl/emw_cs_gen.sv
// Turns the active area index into one active-low select per area.
// Assumes sel_en is high only while an access drives the bus.
module emw_cs_gen #(
    parameter  int N_AREAS = 8,
    localparam int AREA_W  = $clog2(N_AREAS)
) (
    input  logic               sel_en,
    input  logic [AREA_W-1:0]  sel_area,
    output logic [N_AREAS-1:0] cs_n
);
    for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
        // Select line g is low only for the active area.
        assign cs_n[g] = !(sel_en && (sel_area == AREA_W'(g)));
    end
endmodule

// File: rtl/emw_access_seq.sv
// Access sequencer: recovery gap, strobe timing with waits, byte split
// for 8-bit areas, read capture and ready pulse. Each clk tick is half a
// bus cycle. Assumes request fields stay stable until ready.
module emw_access_seq
    import emw_pkg::*;
#(
    parameter  int ADDR_W  = 16,
    parameter  int N_AREAS = 8,
    localparam int AREA_W  = $clog2(N_AREAS),
    localparam int N_PAIRS = N_AREAS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic [AREA_W-1:0] req_area,
    input  area_cfg_t         cfg_all [N_PAIRS],
    output logic [AREA_W-1:0] cur_area,
    output logic              cs_en,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [BUS_W-1:0]  ext_dout,
    output logic              ext_doe,
    input  logic [BUS_W-1:0]  ext_din,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              rsp_ready,
    output logic [BUS_W-1:0]  rsp_rdata
);
    seq_st_t           state;
    logic [3:0]        cnt;
    logic [AREA_W-1:0] area_q;
    logic [AREA_W-1:0] last_area;
    logic              last_vld;
    logic              byte_hi;
    logic [BUS_W-1:0]  rdata_q;
    logic [4:0]        wr_run;

    area_cfg_t new_cfg, cur_cfg, last_cfg;
    logic      split;

    // Final count of one strobe: 2*(1+w)-1 ticks, writes use w >= 1.
    function automatic logic [3:0] stb_last(area_cfg_t c, logic wr);
        logic [2:0] w;
        w = (wr && c.wcnt == 3'd0) ? 3'd1 : c.wcnt;
        return {w, 1'b1};
    endfunction

    // Look up the settings of the incoming, current and previous area.
    always_comb begin
        new_cfg  = cfg_all[req_area[AREA_W-1:1]];
        cur_cfg  = cfg_all[area_q[AREA_W-1:1]];
        last_cfg = cfg_all[last_area[AREA_W-1:1]];
        split    = req_wide && !cur_cfg.wide;
    end

    // Main sequencing: gap, strobe, byte step, ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            area_q    <= '0;
            last_area <= '0;
            last_vld  <= 1'b0;
            byte_hi   <= 1'b0;
            rdata_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    area_q  <= req_area;
                    byte_hi <= 1'b0;
                    if (last_vld && req_area != last_area) begin
                        state <= ST_GAP;
                        cnt   <= {1'b0, last_cfg.od, 1'b0};
                    end else begin
                        state <= ST_STRB;
                        cnt   <= stb_last(new_cfg, req_write);
                    end
                end
                ST_GAP: begin
                    if (cnt == 4'd0) begin
                        state <= ST_STRB;
                        cnt   <= stb_last(cur_cfg, req_write);
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                ST_STRB: begin
                    if (cnt == 4'd0) begin
                        last_area <= area_q;
                        last_vld  <= 1'b1;
                        if (split) begin
                            if (!byte_hi) begin
                                rdata_q[7:0] <= ext_din[7:0];
                                state        <= ST_MID;
                            end else begin
                                rdata_q[15:8] <= ext_din[7:0];
                                state         <= ST_DONE;
                            end
                        end else begin
                            rdata_q <= req_wide ? ext_din : {8'h00, ext_din[7:0]};
                            state   <= ST_DONE;
                        end
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                ST_MID: begin
                    byte_hi <= 1'b1;
                    state   <= ST_STRB;
                    cnt     <= stb_last(cur_cfg, req_write);
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the external bus from the state and the held request.
    always_comb begin
        cs_en     = (state == ST_STRB) || (state == ST_MID);
        cur_area  = area_q;
        ext_rd_n  = !((state == ST_STRB) && !req_write);
        ext_wr_n  = !((state == ST_STRB) && req_write);
        ext_doe   = req_write && cs_en;
        ext_addr  = split ? {req_addr[ADDR_W-1:1], byte_hi} : req_addr;
        ext_dout  = split ? {8'h00, (byte_hi ? req_wdata[15:8] : req_wdata[7:0])}
                          : req_wdata;
        rsp_ready = (state == ST_DONE);
        rsp_rdata = rdata_q;
    end

    // Length of the current write strobe, for the width check.
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_run <= '0;
        else if (!ext_wr_n) wr_run <= wr_run + 5'd1;
        else                wr_run <= '0;
    end

    AST_WR_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr_n && !$past(ext_wr_n)) |-> (wr_run >= 5'd4)); // R3
    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n && !$past(ext_rd_n)) |-> $stable(ext_addr)); // R6
    AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_wr_n && !$past(ext_wr_n)) |-> ($stable(ext_addr) && $stable(ext_dout))); // R6
endmodule

// File: rtl/emw_ctrl.sv
// Top of the per-area external memory wait-state controller.
// Clocked at twice the bus rate; areas come from the top address bits
// and share settings in pairs. Assumes one outstanding request.
module emw_ctrl
    import emw_pkg::*;
#(
    parameter  int ADDR_W  = 16,
    parameter  int N_AREAS = 8,
    localparam int AREA_W  = $clog2(N_AREAS),
    localparam int N_PAIRS = N_AREAS / 2,
    localparam int PAIR_W  = $clog2(N_PAIRS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [PAIR_W-1:0]  cfg_pair,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_wide,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]   req_wdata,
    output logic               rsp_ready,
    output logic [BUS_W-1:0]   rsp_rdata,
    output logic [N_AREAS-1:0] ext_cs_n,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic [BUS_W-1:0]   ext_dout,
    output logic               ext_doe,
    input  logic [BUS_W-1:0]   ext_din,
    output logic               ext_rd_n,
    output logic               ext_wr_n
);
    area_cfg_t         cfg_all [N_PAIRS];
    area_cfg_t         rd_word;
    logic [AREA_W-1:0] req_area;
    logic [AREA_W-1:0] cur_area;
    logic              cs_en;

    assign req_area  = req_addr[ADDR_W-1 -: AREA_W];
    assign cfg_rdata = rd_word;

    emw_cfg_bank #(.N_PAIRS(N_PAIRS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_pair (cfg_pair),
        .wr_data (area_cfg_t'(cfg_wdata)),
        .rd_pair (cfg_pair),
        .rd_data (rd_word),
        .cfg_all (cfg_all)
    );

    emw_access_seq #(.ADDR_W(ADDR_W), .N_AREAS(N_AREAS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_area  (req_area),
        .cfg_all   (cfg_all),
        .cur_area  (cur_area),
        .cs_en     (cs_en),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .ext_doe   (ext_doe),
        .ext_din   (ext_din),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata)
    );

    emw_cs_gen #(.N_AREAS(N_AREAS)) u_cs (
        .sel_en   (cs_en),
        .sel_area (cur_area),
        .cs_n     (ext_cs_n)
    );

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n)); // R1
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n)); // R11
    AST_STB_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n)); // R11
    AST_CS_SWITCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&ext_cs_n) && !(&$past(ext_cs_n))) |-> (ext_cs_n == $past(ext_cs_n))); // R4
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R10
endmodule

// File: tb/sim_emw_ctrl.sv
`timescale 1ns/100ps
module sim_emw_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_pair;
    logic [5:0]  cfg_wdata;
    logic [5:0]  cfg_rdata;
    logic        req_valid, req_write, req_wide;
    logic [15:0] req_addr, req_wdata;
    logic        rsp_ready;
    logic [15:0] rsp_rdata;
    logic [7:0]  ext_cs_n;
    logic [15:0] ext_addr, ext_dout, ext_din;
    logic        ext_doe, ext_rd_n, ext_wr_n;

    always #2.5 clk = ~clk;

    emw_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_pair(cfg_pair), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .ext_cs_n(ext_cs_n), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .ext_din(ext_din), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    // Memory model: read data is a fixed function of the address.
    function automatic logic [15:0] mem16(input logic [15:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] ^ a[7:0]};
    endfunction
    assign ext_din = mem16(ext_addr);

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Strobe monitor, sampled at falling edges.
    bit          mon_on = 1'b0;
    bit          m_prev, m_wr;
    int          m_ticks, m_pulses, m_csbad, m_r11, m_area;
    logic [15:0] m_a0, m_a1, m_d0, m_d1;

    always @(negedge clk) begin
        if (mon_on) begin
            bit stb;
            stb = !ext_rd_n || !ext_wr_n;
            if (stb) begin
                m_ticks++;
                if (!m_prev) begin
                    m_pulses++;
                    if (m_pulses == 1) begin m_a0 = ext_addr; m_d0 = ext_dout; end
                    else begin m_a1 = ext_addr; m_d1 = ext_dout; end
                end
                if (ext_cs_n != ~(8'b1 << m_area)) m_csbad++;
                if ((!ext_rd_n && !ext_wr_n) || (m_wr && !ext_rd_n) || (!m_wr && !ext_wr_n)) m_r11++;
            end
            m_prev = stb;
        end
    end

    // Bench copy of the settings and the last area used.
    logic [5:0] sh_cfg [4];
    int         last_area = 0;
    bit         last_vld = 1'b0;

    task automatic cfg_write(input int p, input logic [5:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_pair = 2'(p); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        sh_cfg[p] = d;
    endtask

    task automatic cfg_check(input int p, input logic [5:0] exp, input string tag);
        @(negedge clk);
        cfg_pair = 2'(p);
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic run_txn(input logic [15:0] a, input bit wr, input bit wide, input logic [15:0] wd);
        int area, pr, w, s, g, lat, n;
        bit split, got, w16;
        logic [15:0] exp_rd, got_rd;
        area  = int'(a[15:13]);
        pr    = area / 2;
        w16   = sh_cfg[pr][5];
        w     = int'(sh_cfg[pr][4:2]);
        if (wr && w == 0) w = 1;
        s     = 2 * (1 + w);
        split = wide && !w16;
        g     = (last_vld && area != last_area) ? 2 * int'(sh_cfg[last_area / 2][1:0]) + 1 : 0;
        lat   = g + (split ? 2 * s + 1 : s) + 1;
        @(negedge clk);
        m_ticks = 0; m_pulses = 0; m_csbad = 0; m_r11 = 0; m_prev = 1'b0;
        m_area = area; m_wr = wr; m_a0 = '0; m_a1 = '0; m_d0 = '0; m_d1 = '0;
        mon_on = 1'b1;
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
        n = 0; got = 1'b0;
        while (!got && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rsp_ready) got = 1'b1;
        end
        got_rd = rsp_rdata;
        mon_on = 1'b0;
        req_valid = 1'b0;
        chk(got && n == lat, "R10 R4 R5 ready latency", n, lat);
        chk(m_ticks == (split ? 2 * s : s), wr ? "R3 write strobe ticks" : "R2 read strobe ticks",
            m_ticks, split ? 2 * s : s);
        chk(m_pulses == (split ? 2 : 1), "R6 strobe count", m_pulses, split ? 2 : 1);
        chk(m_csbad == 0, "R1 chip select", m_csbad, 0);
        chk(m_r11 == 0, "R11 strobe kind", m_r11, 0);
        if (split) begin
            chk(m_a0 == {a[15:1], 1'b0}, "R6 first byte address", m_a0, {a[15:1], 1'b0});
            chk(m_a1 == {a[15:1], 1'b1}, "R6 second byte address", m_a1, {a[15:1], 1'b1});
        end else begin
            chk(m_a0 == a, "R7 single address", m_a0, a);
        end
        if (wr) begin
            if (split) begin
                chk(m_d0[7:0] == wd[7:0], "R6 low byte first", m_d0[7:0], wd[7:0]);
                chk(m_d1[7:0] == wd[15:8], "R6 high byte second", m_d1[7:0], wd[15:8]);
            end else begin
                chk(m_d0 == wd, "R7 write data", m_d0, wd);
            end
        end else begin
            if (split)     exp_rd = {mem16({a[15:1], 1'b1})[7:0], mem16({a[15:1], 1'b0})[7:0]};
            else if (wide) exp_rd = mem16(a);
            else           exp_rd = {8'h00, mem16(a)[7:0]};
            chk(got_rd == exp_rd, split ? "R6 assembled read" : "R7 R10 read data", got_rd, exp_rd);
        end
        @(negedge clk);
        chk(!rsp_ready, "R10 ready one tick", rsp_ready, 0);
        last_area = area;
        last_vld  = 1'b1;
    endtask

    // Vector table: {write, wide, address, write data}.
    localparam logic [33:0] TBL [10] = '{
        {1'b0, 1'b1, 16'h0124, 16'h0000},
        {1'b0, 1'b1, 16'h0126, 16'h0000},
        {1'b1, 1'b1, 16'h4230, 16'hBEEF},
        {1'b0, 1'b1, 16'h6452, 16'h0000},
        {1'b1, 1'b0, 16'h6011, 16'h0077},
        {1'b0, 1'b0, 16'hE0F1, 16'h0000},
        {1'b1, 1'b1, 16'hC002, 16'h1234},
        {1'b0, 1'b1, 16'h2AAA, 16'h0000},
        {1'b1, 1'b1, 16'h2AAC, 16'h5A5A},
        {1'b0, 1'b1, 16'h8888, 16'h0000}
    };

    initial begin
        for (int i = 0; i < 4; i++) sh_cfg[i] = 6'h3F;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_pair = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_cs_n == 8'hFF, "R8 selects idle", ext_cs_n, 8'hFF);
        chk(ext_rd_n && ext_wr_n, "R8 strobes idle", {ext_rd_n, ext_wr_n}, 2'b11);
        chk(!rsp_ready, "R8 ready low", rsp_ready, 0);
        for (int p = 0; p < 4; p++) cfg_check(p, 6'h3F, "R8 default setting");

        // First access after reset: no gap; slow default timing.
        run_txn(16'h8010, 1'b0, 1'b1, 16'h0000);
        // Area change under defaults: gap of 7 ticks.
        run_txn(16'h0010, 1'b0, 1'b1, 16'h0000);

        cfg_write(0, 6'h20);
        cfg_write(1, 6'h06);
        cfg_write(3, 6'h29);
        cfg_check(0, 6'h20, "R9 readback pair 0");
        cfg_check(1, 6'h06, "R9 readback pair 1");
        cfg_check(2, 6'h3F, "R9 untouched pair");
        cfg_check(3, 6'h29, "R9 readback pair 3");

        for (int i = 0; i < 10; i++)
            run_txn(TBL[i][31:16], TBL[i][33], TBL[i][32], TBL[i][15:0]);

        // Pair sharing and the shortest gap.
        cfg_write(1, 6'h20);
        cfg_check(1, 6'h20, "R9 rewrite pair 1");
        run_txn(16'h4000, 1'b0, 1'b1, 16'h0000);
        run_txn(16'h6002, 1'b0, 1'b1, 16'h0000);
        run_txn(16'h6004, 1'b1, 1'b1, 16'hA5C3);
        run_txn(16'h6006, 1'b0, 1'b0, 16'h0000);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule